// File: doc/BRIEF.md
# Banked Host Register Interface with Operating-Mode Gating

This block sits between a byte-wide host port and the input/output, counter and serial-line logic of a chip. The host sees sixteen byte locations through a 4-bit offset. A bank register picks one of three pages behind those sixteen locations, and it can be reached at the top offset of every page. A separate mode register decides whether the host is configuring the chip or running it. Configuration registers accept writes only in configuration mode, and only when their own page is selected. The digital output latch accepts writes only in run mode. A few locations ignore both gates: the bank register, the mode register, the digital input port and the prescale-load strokes.

The block keeps the register values and drives them straight to its neighbours. These values are the counter enables, edge polarities, input route masks, the 16-bit prescale word, the line-termination and differential-mode controls, and the digital output nibble. Writing the reserved clear code to the mode register returns every register to zero in one clock. Read data is combinational and is zero when no read is strobed.

Top module: `mode_bank_regs`

## Requirements
- R1: The bank register is at offset 0xF in every page. It stores a written value of 0, 1 or 2, and reading offset 0xF in any page returns the stored value.
- R2: A write of a value above 2 to offset 0xF is ignored, and the previous page stays selected.
- R3: The mode register is at page 1 offset 0x4 and can be read back there in any mode. Code 0x2 means configuration mode and code 0x3 means run mode.
- R4: A write of 0xF to the mode register clears every register to zero at the same clock edge, including the bank and mode registers. After it, the mode register reads 0x0 and all control outputs are zero.
- R5: Page 0 offset 0x0 loads the digital output from write-data bits 3:0. This happens only in run mode.
- R6: Offset 0x1 reads the digital input, zero-extended to 8 bits, in every page and every mode.
- R7: The following registers update only in configuration mode with the right page selected. In page 0: edge polarity at 0x2, bit i for counter i, where 1 means rising. Line control at 0x5. Route masks at 0xA+i for counter i. Counter enables at 0xE, bits 3:0 for the counters and bit 4 for the odometer. In page 1: prescale low byte at 0x1 and prescale high byte at 0x2.
- R8: Line-control bit 0 drives the termination enable. Line-control bit 1 drives the differential-mode select.
- R9: Page 1 offset 0x7 reads the capability byte in configuration mode and 0x00 in any other mode. Bits 2:0 give the counter count, bit 3 is 1 when an odometer is present, bits 6:4 give the revision, and bit 7 is 0.
- R10: A write of any value to page 2 at offset 0x6+i gives a one-clock pulse on load strobe i for counter i, and offset 0xA gives a pulse on the odometer strobe (the top strobe bit). The pulse appears in the clock after the write edge, in any mode.
- R11: Page 2 reads the route masks of counters 0 to 3 at offsets 0x2, 0x3, 0x5 and 0x6. Page 1 offset 0x2 reads the edge polarity byte in configuration mode.
- R12: Reads of unused offsets return 0x00, and read data is 0x00 while no read is strobed. A write rejected by the page or mode gate leaves every output and every readable register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one clock per write |
| rd_en | input | 1 | Host read strobe |
| addr | input | 4 | Offset within the selected page |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Host read data, combinational |
| din | input | DIN_W (7) | Digital input pins |
| dout | output | DOUT_W (4) | Digital output latch |
| com_term | output | 1 | Line termination enable |
| com_diff | output | 1 | Differential line mode select |
| cnt_en | output | NUM_CNT (4) | Counter enables |
| odo_en | output | 1 | Odometer enable |
| edge_rise | output | NUM_CNT (4) | Per-counter edge polarity, 1 = rising |
| route_mask | output | 8*NUM_CNT (32) | Input route masks, counter i in bits 8i+7:8i |
| prescale | output | 16 | Prescale word {high byte, low byte} |
| load_pulse | output | NUM_CNT+1 (5) | Prescale load strobes, top bit for the odometer |

## Verification
The bench builds the block with four counters, an odometer and a revision of 5. With these values every capability field holds a distinct non-zero pattern, so a swapped or shifted field shows up in the readback. All four route masks and all five load strobes are present, which lets the bench reach the irregular route readback offsets and the odometer strobe at 0xA. The bench drives the mode register through idle, configuration, run and clear, and it writes in the wrong page and the wrong mode at each of them.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

  localparam int BYTE_W  = 8;
  localparam int OFS_W   = 4;
  localparam int MAX_CNT = 4;
  localparam int ODO_BIT = 4;

  localparam logic [1:0] LAST_BANK = 2'd2;

  // operating-mode codes held in the mode register
  localparam logic [3:0] FS_CFG = 4'h2;
  localparam logic [3:0] FS_RUN = 4'h3;
  localparam logic [3:0] FS_CLR = 4'hF;

  // offsets reachable from every page
  localparam logic [3:0] OFS_BANK  = 4'hF;
  localparam logic [3:0] OFS_DIN   = 4'h1;
  // page 0
  localparam logic [3:0] OFS_DOUT   = 4'h0;
  localparam logic [3:0] OFS_EDGE   = 4'h2;
  localparam logic [3:0] OFS_COM    = 4'h5;
  localparam logic [3:0] OFS_ROUTE0 = 4'hA;
  localparam logic [3:0] OFS_IMODE  = 4'hE;
  // page 1
  localparam logic [3:0] OFS_PS_LO = 4'h1;
  localparam logic [3:0] OFS_PS_HI = 4'h2;
  localparam logic [3:0] OFS_FSEL  = 4'h4;
  localparam logic [3:0] OFS_CAP   = 4'h7;
  localparam logic [3:0] OFS_EDGE_RD = 4'h2;
  // page 2
  localparam logic [3:0] OFS_LOAD0    = 4'h6;
  localparam logic [3:0] OFS_LOAD_ODO = 4'hA;

  typedef struct packed {
    logic               bank;
    logic               fsel;
    logic               clr;
    logic               dout;
    logic               edge_sel;
    logic               com;
    logic               imode;
    logic               ps_lo;
    logic               ps_hi;
    logic [MAX_CNT-1:0] route;
    logic [MAX_CNT:0]   load;
  } wsel_t;

  // capability byte: {0, revision, odometer flag, counter count}
  function automatic logic [BYTE_W-1:0] cap_byte(input int unsigned ncnt,
                                                 input bit odo,
                                                 input logic [2:0] rev);
    logic [2:0] n3;
    n3 = 3'(ncnt);
    return {1'b0, rev, odo, n3};
  endfunction

  // page-2 readback offset of the route mask of counter i
  function automatic logic [OFS_W-1:0] route_rd_ofs(input int unsigned i);
    case (i)
      0:       return 4'h2;
      1:       return 4'h3;
      2:       return 4'h5;
      default: return 4'h6;
    endcase
  endfunction

  function automatic logic [OFS_W-1:0] ofs_plus(input logic [OFS_W-1:0] base,
                                                input int unsigned i);
    return OFS_W'(int'(base) + int'(i));
  endfunction

endpackage

// File: rtl/mbr_access_gate.sv
module mbr_access_gate
  import mbr_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter bit HAS_ODO = 1'b1
) (
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [1:0]        bank,
  input  logic [3:0]        fsel,
  output wsel_t             sel
);

  logic in_cfg;
  logic in_run;

  assign in_cfg = (fsel == FS_CFG);
  assign in_run = (fsel == FS_RUN);

  always_comb begin
    sel = '0;
    if (wr_en) begin
      if (addr == OFS_BANK)
        sel.bank = (wr_data <= BYTE_W'(LAST_BANK));
      case (bank)
        2'd0: begin
          if (in_run && addr == OFS_DOUT) sel.dout = 1'b1;
          if (in_cfg) begin
            sel.edge_sel = (addr == OFS_EDGE);
            sel.com      = (addr == OFS_COM);
            sel.imode    = (addr == OFS_IMODE);
            for (int i = 0; i < NUM_CNT; i++)
              sel.route[i] = (addr == ofs_plus(OFS_ROUTE0, i));
          end
        end
        2'd1: begin
          if (addr == OFS_FSEL) begin
            if (wr_data[3:0] == FS_CLR) sel.clr = 1'b1;
            else                        sel.fsel = 1'b1;
          end
          if (in_cfg) begin
            sel.ps_lo = (addr == OFS_PS_LO);
            sel.ps_hi = (addr == OFS_PS_HI);
          end
        end
        2'd2: begin
          for (int i = 0; i < NUM_CNT; i++)
            sel.load[i] = (addr == ofs_plus(OFS_LOAD0, i));
          if (HAS_ODO) sel.load[MAX_CNT] = (addr == OFS_LOAD_ODO);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mbr_cfg_store.sv
module mbr_cfg_store
  import mbr_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int DOUT_W  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  wsel_t                       sel,
  input  logic [BYTE_W-1:0]           wr_data,
  output logic [1:0]                  bank_q,
  output logic [3:0]                  fsel_q,
  output logic [DOUT_W-1:0]           dout_q,
  output logic [NUM_CNT-1:0]          edge_q,
  output logic [1:0]                  com_q,
  output logic [ODO_BIT:0]            imode_q,
  output logic [15:0]                 prescale_q,
  output logic [NUM_CNT*BYTE_W-1:0]   route_flat,
  output logic [MAX_CNT:0]            load_q
);

  logic [NUM_CNT-1:0][BYTE_W-1:0] route_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q     <= '0;
      fsel_q     <= '0;
      dout_q     <= '0;
      edge_q     <= '0;
      com_q      <= '0;
      imode_q    <= '0;
      prescale_q <= '0;
      load_q     <= '0;
    end else if (sel.clr) begin
      bank_q     <= '0;
      fsel_q     <= '0;
      dout_q     <= '0;
      edge_q     <= '0;
      com_q      <= '0;
      imode_q    <= '0;
      prescale_q <= '0;
      load_q     <= '0;
    end else begin
      if (sel.bank)     bank_q  <= wr_data[1:0];
      if (sel.fsel)     fsel_q  <= wr_data[3:0];
      if (sel.dout)     dout_q  <= wr_data[DOUT_W-1:0];
      if (sel.edge_sel) edge_q  <= wr_data[NUM_CNT-1:0];
      if (sel.com)      com_q   <= wr_data[1:0];
      if (sel.imode)    imode_q <= wr_data[ODO_BIT:0];
      if (sel.ps_lo)    prescale_q[7:0]  <= wr_data;
      if (sel.ps_hi)    prescale_q[15:8] <= wr_data;
      load_q <= sel.load;
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_route
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            route_q[g] <= '0;
      else if (sel.clr)      route_q[g] <= '0;
      else if (sel.route[g]) route_q[g] <= wr_data;
    end
    assign route_flat[g*BYTE_W +: BYTE_W] = route_q[g];
  end

endmodule

// File: rtl/mbr_read_mux.sv
module mbr_read_mux
  import mbr_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int DIN_W   = 7
) (
  input  logic                      rd_en,
  input  logic [OFS_W-1:0]          addr,
  input  logic [1:0]                bank,
  input  logic [3:0]                fsel,
  input  logic [DIN_W-1:0]          din,
  input  logic [NUM_CNT-1:0]        edge_q,
  input  logic [NUM_CNT*BYTE_W-1:0] route_flat,
  input  logic [BYTE_W-1:0]         cap,
  output logic [BYTE_W-1:0]         rd_data
);

  logic [BYTE_W-1:0] pick;
  logic              in_cfg;

  assign in_cfg = (fsel == FS_CFG);

  always_comb begin
    pick = '0;
    if (addr == OFS_BANK) begin
      pick = BYTE_W'(bank);
    end else if (addr == OFS_DIN) begin
      pick = BYTE_W'(din);
    end else begin
      case (bank)
        2'd1: begin
          if (addr == OFS_FSEL)                pick = BYTE_W'(fsel);
          else if (in_cfg && addr == OFS_CAP)  pick = cap;
          else if (in_cfg && addr == OFS_EDGE_RD) pick = BYTE_W'(edge_q);
        end
        2'd2: begin
          for (int i = 0; i < NUM_CNT; i++)
            if (addr == route_rd_ofs(i)) pick = route_flat[i*BYTE_W +: BYTE_W];
        end
        default: ;
      endcase
    end
  end

  assign rd_data = rd_en ? pick : '0;

endmodule

// File: rtl/mode_bank_regs.sv
module mode_bank_regs
  import mbr_pkg::*;
#(
  parameter int         NUM_CNT  = 4,
  parameter bit         HAS_ODO  = 1'b1,
  parameter logic [2:0] REVISION = 3'd2,
  parameter int         DIN_W    = 7,
  parameter int         DOUT_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [3:0]                addr,
  input  logic [7:0]                wr_data,
  output logic [7:0]                rd_data,
  input  logic [DIN_W-1:0]          din,
  output logic [DOUT_W-1:0]         dout,
  output logic                      com_term,
  output logic                      com_diff,
  output logic [NUM_CNT-1:0]        cnt_en,
  output logic                      odo_en,
  output logic [NUM_CNT-1:0]        edge_rise,
  output logic [NUM_CNT*8-1:0]      route_mask,
  output logic [15:0]               prescale,
  output logic [NUM_CNT:0]          load_pulse
);

  localparam logic [BYTE_W-1:0] CAP = cap_byte(NUM_CNT, HAS_ODO, REVISION);

  wsel_t              sel;
  logic               soft_clr;
  logic [1:0]         bank_q;
  logic [3:0]         fsel_q;
  logic [1:0]         com_q;
  logic [ODO_BIT:0]   imode_q;
  logic [MAX_CNT:0]   load_q;

  assign soft_clr = sel.clr;

  mbr_access_gate #(.NUM_CNT(NUM_CNT), .HAS_ODO(HAS_ODO)) u_gate (
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .bank    (bank_q),
    .fsel    (fsel_q),
    .sel     (sel)
  );

  mbr_cfg_store #(.NUM_CNT(NUM_CNT), .DOUT_W(DOUT_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .wr_data    (wr_data),
    .bank_q     (bank_q),
    .fsel_q     (fsel_q),
    .dout_q     (dout),
    .edge_q     (edge_rise),
    .com_q      (com_q),
    .imode_q    (imode_q),
    .prescale_q (prescale),
    .route_flat (route_mask),
    .load_q     (load_q)
  );

  mbr_read_mux #(.NUM_CNT(NUM_CNT), .DIN_W(DIN_W)) u_rmux (
    .rd_en      (rd_en),
    .addr       (addr),
    .bank       (bank_q),
    .fsel       (fsel_q),
    .din        (din),
    .edge_q     (edge_rise),
    .route_flat (route_mask),
    .cap        (CAP),
    .rd_data    (rd_data)
  );

  assign com_term   = com_q[0];
  assign com_diff   = com_q[1];
  assign cnt_en     = imode_q[NUM_CNT-1:0];
  assign odo_en     = imode_q[ODO_BIT] & HAS_ODO;
  assign load_pulse = {load_q[MAX_CNT], load_q[NUM_CNT-1:0]};

endmodule

// File: rtl/mbr_checker.sv
module mbr_checker
  import mbr_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int DOUT_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               rd_en,
  input logic [3:0]         addr,
  input logic [7:0]         wr_data,
  input logic [7:0]         rd_data,
  input logic [DOUT_W-1:0]  dout,
  input logic               com_term,
  input logic               com_diff,
  input logic [NUM_CNT:0]   load_pulse,
  input logic [1:0]         bank_q,
  input logic [3:0]         fsel_q,
  input logic               soft_clr
);

  AST_BANK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q <= LAST_BANK); // R1

  AST_BANK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_BANK && wr_data > 8'd2) |=> $stable(bank_q)); // R2

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (bank_q == 2'd0 && fsel_q == 4'h0 && dout == '0
                  && !com_term && !com_diff)); // R4

  AST_DOUT_RUN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> ($past(fsel_q) == FS_RUN || $past(soft_clr))); // R5

  AST_LINE_CFG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({com_term, com_diff}) |->
      (($past(fsel_q) == FS_CFG && $past(bank_q) == 2'd0) || $past(soft_clr))); // R7

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_pulse)); // R10

  AST_LOAD_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse != '0) |=> ($past(load_pulse) != load_pulse || load_pulse == '0
                            || $past(wr_en))); // R10

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == 8'h00); // R12

endmodule

bind mode_bank_regs mbr_checker #(.NUM_CNT(NUM_CNT), .DOUT_W(DOUT_W)) u_mbr_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .dout       (dout),
  .com_term   (com_term),
  .com_diff   (com_diff),
  .load_pulse (load_pulse),
  .bank_q     (bank_q),
  .fsel_q     (fsel_q),
  .soft_clr   (soft_clr)
);

// File: tb/test_mode_bank_regs.sv
module test_mode_bank_regs;

  localparam int         NC  = 4;
  localparam logic [2:0] REV = 3'd5;
  // capability restated: revision in the upper nibble, odometer flag, count
  localparam logic [7:0] CAP_EXP = 8'((int'(REV) << 4) | (1 << 3) | NC);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [6:0]  din = 7'h5A;
  logic [3:0]  dout;
  logic        com_term, com_diff, odo_en;
  logic [3:0]  cnt_en, edge_rise;
  logic [31:0] route_mask;
  logic [15:0] prescale;
  logic [4:0]  load_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mode_bank_regs #(.NUM_CNT(NC), .HAS_ODO(1'b1), .REVISION(REV)) i_mode_bank_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .din(din), .dout(dout),
    .com_term(com_term), .com_diff(com_diff), .cnt_en(cnt_en), .odo_en(odo_en),
    .edge_rise(edge_rise), .route_mask(route_mask), .prescale(prescale),
    .load_pulse(load_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rd_data;
    rd_en = 1'b0;
  endtask

  // {is_read, offset, data or expected, requirement number}
  localparam int NV = 28;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 4'hF, 8'h01, 4'd1},   // R1 select page 1
    {1'b1, 4'hF, 8'h01, 4'd1},   // R1
    {1'b0, 4'h4, 8'h02, 4'd3},   // R3 configuration mode
    {1'b1, 4'h4, 8'h02, 4'd3},   // R3
    {1'b1, 4'h7, CAP_EXP, 4'd9}, // R9
    {1'b0, 4'h1, 8'h34, 4'd7},   // R7 prescale low
    {1'b0, 4'h2, 8'h12, 4'd7},   // R7 prescale high
    {1'b0, 4'hF, 8'h00, 4'd1},
    {1'b0, 4'h2, 8'h0A, 4'd7},
    {1'b0, 4'h5, 8'h03, 4'd8},   // R8
    {1'b0, 4'hA, 8'h11, 4'd7},
    {1'b0, 4'hB, 8'h22, 4'd7},
    {1'b0, 4'hC, 8'h44, 4'd7},
    {1'b0, 4'hD, 8'h88, 4'd7},
    {1'b0, 4'hE, 8'h1F, 4'd7},
    {1'b0, 4'hF, 8'h07, 4'd2},   // R2 illegal page
    {1'b1, 4'hF, 8'h00, 4'd2},   // R2
    {1'b0, 4'hF, 8'h02, 4'd1},
    {1'b1, 4'hF, 8'h02, 4'd1},
    {1'b1, 4'h2, 8'h11, 4'd11},  // R11
    {1'b1, 4'h3, 8'h22, 4'd11},
    {1'b1, 4'h5, 8'h44, 4'd11},
    {1'b1, 4'h6, 8'h88, 4'd11},
    {1'b1, 4'h1, 8'h5A, 4'd6},   // R6
    {1'b1, 4'h0, 8'h00, 4'd12},  // R12
    {1'b1, 4'hE, 8'h00, 4'd12},
    {1'b0, 4'hF, 8'h01, 4'd1},
    {1'b1, 4'h2, 8'h0A, 4'd11}
  };

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state (R4 zero state)
    rd(4'hF, r);
    chk("R4 reset page", {24'h0, r}, 32'h0);
    chk("R4 reset outputs", {dout, com_term, com_diff, odo_en, cnt_en, edge_rise},
        32'h0);
    chk("R4 reset routes", route_mask, 32'h0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][16]) begin
        rd(VEC[k][15:12], r);
        chk($sformatf("R%0d table step %0d", VEC[k][3:0], k), {24'h0, r},
            {24'h0, VEC[k][11:4]});
      end else begin
        wr(VEC[k][15:12], VEC[k][11:4]);
      end
    end

    chk("R7 prescale", {16'h0, prescale}, 32'h1234);
    chk("R8 line control", {30'h0, com_diff, com_term}, 32'h3);
    chk("R7 enables", {27'h0, odo_en, cnt_en}, 32'h1F);
    chk("R7 edge", {28'h0, edge_rise}, 32'hA);
    chk("R7 routes", route_mask, 32'h88442211);

    // page 1: page-0 config offsets are not targets here
    wr(4'hA, 8'h55);
    wr(4'h5, 8'h00);
    chk("R12 wrong-page route", route_mask, 32'h88442211);
    chk("R12 wrong-page line", {30'h0, com_diff, com_term}, 32'h3);

    // digital output blocked in configuration mode
    wr(4'hF, 8'h00);
    wr(4'h0, 8'h0F);
    chk("R5 dout in cfg", {28'h0, dout}, 32'h0);

    // run mode
    wr(4'hF, 8'h01);
    wr(4'h4, 8'h03);
    rd(4'h4, r);
    chk("R3 run code", {24'h0, r}, 32'h03);
    rd(4'h7, r);
    chk("R9 cap hidden in run", {24'h0, r}, 32'h0);
    rd(4'h2, r);
    chk("R11 edge hidden in run", {24'h0, r}, 32'h0);
    wr(4'h1, 8'hEE);
    chk("R7 prescale locked in run", {16'h0, prescale}, 32'h1234);
    wr(4'hF, 8'h00);
    wr(4'h0, 8'hF6);
    chk("R5 dout in run", {28'h0, dout}, 32'h6);
    wr(4'h5, 8'h00);
    wr(4'hE, 8'h00);
    chk("R7 line locked in run", {30'h0, com_diff, com_term}, 32'h3);
    chk("R7 enables locked in run", {27'h0, odo_en, cnt_en}, 32'h1F);
    din = 7'h25;
    rd(4'h1, r);
    chk("R6 din in run", {24'h0, r}, 32'h25);

    // load strobes, page 2
    wr(4'hF, 8'h02);
    wr(4'h6, 8'h00);
    chk("R10 load 0 pulse", {27'h0, load_pulse}, 32'h01);
    @(negedge clk);
    chk("R10 load 0 one clock", {27'h0, load_pulse}, 32'h00);
    wr(4'hA, 8'h77);
    chk("R10 odometer load", {27'h0, load_pulse}, 32'h10);
    wr(4'h9, 8'h00);
    chk("R10 load 3", {27'h0, load_pulse}, 32'h08);

    // no read strobe
    @(negedge clk);
    addr = 4'hF;
    #1 chk("R12 idle read", {24'h0, rd_data}, 32'h0);

    // soft clear
    wr(4'hF, 8'h01);
    wr(4'h4, 8'h0F);
    chk("R4 clear outputs", {dout, com_term, com_diff, odo_en, cnt_en, edge_rise},
        32'h0);
    chk("R4 clear prescale", {16'h0, prescale}, 32'h0);
    chk("R4 clear routes", route_mask, 32'h0);
    rd(4'hF, r);
    chk("R4 clear page", {24'h0, r}, 32'h0);
    wr(4'hF, 8'h01);
    rd(4'h4, r);
    chk("R4 mode reads zero", {24'h0, r}, 32'h0);
    rd(4'h1, r);
    chk("R6 din in idle mode", {24'h0, r}, 32'h25);
    wr(4'hF, 8'h00);
    wr(4'h5, 8'h03);
    chk("R7 line locked after clear", {30'h0, com_diff, com_term}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule